// File: doc/BRIEF.md
# Mode-Controlled Eight-Way Addressable Latch

This block holds eight "driver ON" flags for a bank of low-side switches. A 3-bit address picks one flag, a single data bit gives its new value, and two active-low controls, an enable and a clear, pick one of four modes. The modes are: write one flag and keep the others; hold all flags; decode, where the addressed flag takes the data bit and every other flag is forced off; and clear all flags.

All inputs are sampled on the rising clock edge. The flags are registers, so a change that is sampled at one edge is visible on the outputs right after that edge. A synchronous reset turns every flag off. A flag at 1 means its driver is ON and sinks current. A flag at 0 means the driver is OFF.

Top module: `octal_addr_latch`

## Requirements
- R1: There are eight flags. The 3-bit address is read as a binary number n, from 0 to 7, and it selects drvOn[n].
- R2: The mode code is {clearN, enableN}. 2'b10 selects latch, 2'b11 selects hold, 2'b00 selects decode and 2'b01 selects clear.
- R3: In latch mode, drvOn[addr] takes dataIn and the other seven flags keep their values.
- R4: In hold mode, all flags keep their values whatever dataIn and the address are. Changing the address while enableN is high writes nothing.
- R5: In decode mode, drvOn[addr] takes dataIn and every other flag becomes 0. At most one flag is 1 after such a cycle.
- R6: In clear mode, all flags become 0 whatever dataIn and the address are.
- R7: A synchronous reset (rst high at a rising edge) sets all flags to 0, whatever the mode inputs are.
- R8: Inputs are sampled on the rising edge. drvOn changes only right after that edge and stays stable between edges.
- R9: Going from decode mode to hold mode keeps the one-hot or all-zero pattern that the decode produced.
- R10: A flag is 1 (driver ON) when the data bit stored for it was 1, and 0 (driver OFF) when that bit was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge sampling |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | 3 | Flag select |
| dataIn | input | 1 | Data bit to store |
| enableN | input | 1 | Active-low enable |
| clearN | input | 1 | Active-low clear |
| drvOn | output | 8 | Driver-ON flags |

## Verification
Several checks run on every cycle: hold mode leaves the flags unchanged, latch mode changes only the addressed flag, decode mode leaves at most one flag set, clear mode and reset leave every flag at zero, and the address decode is always one-hot. Other behaviours can only be shown by the bench scenarios. These are the exact value that lands in the addressed position, the mapping of every address to its output bit, and the pattern kept when decode mode hands over to hold. The bench also checks the edge timing, by observing the outputs just before and just after a sampling edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode code is {clearN, enableN}
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_LATCH  = 2'b10,
    MODE_HOLD   = 2'b11
  } mode_e;

  // Strobes from control to the flag bank
  typedef struct packed {
    logic wrEn;      // write dataBit into the selected flag
    logic zeroRest;  // force the non-written flags to zero
    logic dataBit;   // value to write
  } strobe_t;

endpackage

// File: rtl/latch_mode_ctrl.sv
module latch_mode_ctrl
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               dataIn,
  input  logic               enableN,
  input  logic               clearN,
  output strobe_t            stb,
  output logic [NUM_OUT-1:0] sel
);

  mode_e mode;

  // R2: mode decode from the two active-low controls
  assign mode = mode_e'({clearN, enableN});

  always_comb begin
    stb.dataBit  = dataIn;
    stb.wrEn     = 1'b0;
    stb.zeroRest = 1'b0;
    unique case (mode)
      MODE_LATCH:  begin stb.wrEn = 1'b1; stb.zeroRest = 1'b0; end
      MODE_DECODE: begin stb.wrEn = 1'b1; stb.zeroRest = 1'b1; end
      MODE_CLEAR:  begin stb.wrEn = 1'b0; stb.zeroRest = 1'b1; end
      default:     begin stb.wrEn = 1'b0; stb.zeroRest = 1'b0; end
    endcase
  end

  // R1: binary address to one-hot select
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_sel
    assign sel[i] = (addrIn == ADDR_W'(i));
  end

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel));

endmodule

// File: rtl/latch_flag_bank.sv
module latch_flag_bank
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [NUM_OUT-1:0] sel,
  output logic [NUM_OUT-1:0] flags
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flags[i] <= 1'b0;        // R7
      else if (stb.wrEn && sel[i])  flags[i] <= stb.dataBit; // R3 R5 R10
      else if (stb.zeroRest)        flags[i] <= 1'b0;        // R5 R6
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!stb.wrEn && !stb.zeroRest) |=> $stable(flags));

  p_clear_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!stb.wrEn && stb.zeroRest) |=> (flags == '0));

  p_decode_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && stb.zeroRest) |=> $onehot0(flags));

  p_latch_others_r3: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && !stb.zeroRest) |=> (((flags ^ $past(flags)) & ~$past(sel)) == '0));

  p_reset_off_r7: assert property (@(posedge clk)
    rst |=> (flags == '0));

endmodule

// File: rtl/octal_addr_latch.sv
module octal_addr_latch
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               dataIn,
  input  logic               enableN,
  input  logic               clearN,
  output logic [NUM_OUT-1:0] drvOn
);

  strobe_t            stb;
  logic [NUM_OUT-1:0] sel;

  latch_mode_ctrl #(.NUM_OUT(NUM_OUT)) i_ctrl (
    .clk(clk), .rst(rst), .addrIn(addrIn), .dataIn(dataIn),
    .enableN(enableN), .clearN(clearN), .stb(stb), .sel(sel)
  );

  latch_flag_bank #(.NUM_OUT(NUM_OUT)) i_bank (
    .clk(clk), .rst(rst), .stb(stb), .sel(sel), .flags(drvOn)
  );

endmodule

// File: tb/test_octal_addr_latch.sv
`timescale 1ns/1ps
module test_octal_addr_latch;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] addrIn;
  logic       dataIn;
  logic       enableN;
  logic       clearN;
  logic [7:0] drvOn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  octal_addr_latch i_octal_addr_latch (
    .clk(clk), .rst(rst), .addrIn(addrIn), .dataIn(dataIn),
    .enableN(enableN), .clearN(clearN), .drvOn(drvOn)
  );

  // vector: {clearN, enableN, addr[2:0], data, expected[7:0]}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    {2'b10, 3'd3, 1'b1, 8'h08},  // R3 latch
    {2'b10, 3'd0, 1'b1, 8'h09},  // R3
    {2'b10, 3'd7, 1'b1, 8'h89},  // R3
    {2'b10, 3'd3, 1'b0, 8'h81},  // R10 data low turns off
    {2'b11, 3'd5, 1'b1, 8'h81},  // R4 hold
    {2'b11, 3'd2, 1'b0, 8'h81},  // R4 address moves, nothing written
    {2'b00, 3'd6, 1'b1, 8'h40},  // R5 decode
    {2'b11, 3'd1, 1'b1, 8'h40},  // R9 keep decode pattern
    {2'b00, 3'd2, 1'b0, 8'h00},  // R5 decode with data low
    {2'b10, 3'd4, 1'b1, 8'h10},  // R3
    {2'b10, 3'd1, 1'b1, 8'h12},  // R3
    {2'b01, 3'd1, 1'b1, 8'h00},  // R6 clear
    {2'b10, 3'd5, 1'b1, 8'h20},  // R3
    {2'b00, 3'd5, 1'b1, 8'h20},  // R5
    {2'b11, 3'd0, 1'b0, 8'h20}   // R9
  };
  localparam int VTAG [NV] = '{3,3,3,10,4,4,5,9,5,3,3,6,3,5,9};

  task automatic check(input logic [7:0] exp, input string tag);
    nChecks++;
    if (drvOn !== exp) begin
      nFails++;
      $display("FAIL %s: drvOn=%h expected=%h", tag, drvOn, exp);
    end
  endtask

  // drive at negedge, result sampled at next negedge
  task automatic apply(input logic cN, input logic eN, input logic [2:0] a,
                       input logic d);
    @(negedge clk);
    clearN = cN; enableN = eN; addrIn = a; dataIn = d;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; clearN = 1'b1; enableN = 1'b1; addrIn = '0; dataIn = 1'b0;
    repeat (3) @(negedge clk);
    check(8'h00, "R7 reset state");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][13], VEC[k][12], VEC[k][11:9], VEC[k][8]);
      check(VEC[k][7:0], $sformatf("R%0d vector %0d", VTAG[k], k));
    end

    // R1: every address maps to its own bit (decode one at a time)
    for (int a = 0; a < 8; a++) begin
      apply(1'b0, 1'b0, 3'(a), 1'b1);
      check(8'(1 << a), $sformatf("R1 decode address %0d", a));
    end

    // R2: each mode code from a known state 8'h0F
    apply(1'b0, 1'b1, 3'd0, 1'b0);
    for (int a = 0; a < 4; a++) apply(1'b1, 1'b0, 3'(a), 1'b1);
    check(8'h0F, "R2 latch code 10 build");
    apply(1'b1, 1'b1, 3'd6, 1'b1);
    check(8'h0F, "R2 hold code 11");
    apply(1'b0, 1'b0, 3'd6, 1'b1);
    check(8'h40, "R2 decode code 00");
    apply(1'b0, 1'b1, 3'd6, 1'b1);
    check(8'h00, "R2 clear code 01");

    // R8: output changes only after the sampling edge
    @(negedge clk);
    clearN = 1'b1; enableN = 1'b0; addrIn = 3'd2; dataIn = 1'b1;
    #3;
    check(8'h00, "R8 before edge");
    @(posedge clk); #1;
    check(8'h04, "R8 after edge");
    #5;
    check(8'h04, "R8 stable between edges");
    enableN = 1'b1;

    // R7: reset wins over latch mode
    for (int a = 0; a < 8; a++) apply(1'b1, 1'b0, 3'(a), 1'b1);
    check(8'hFF, "R7 all set before reset");
    @(negedge clk);
    rst = 1'b1; clearN = 1'b1; enableN = 1'b0; addrIn = 3'd3; dataIn = 1'b1;
    @(negedge clk);
    check(8'h00, "R7 reset over latch mode");
    rst = 1'b0; enableN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule